// File: doc/BRIEF.md
# Statistics Counter Bank with Rollover Interrupts

This block holds a bank of free-running 32-bit event counters for network statistics. Counters 0 to 14 form the transmit group and counters 15 to 39 form the receive group. Each counter advances by one on a single-cycle pulse on its bit of `ev_inc`. The MAC logic that produces these pulses sits outside the block.

Software never addresses a counter directly. It programs an access control register with a counter index, a direction, a clear-on-read option and an auto-advance option. It then reads or writes a single data register. With auto-advance enabled, software can sweep the whole bank with repeated data accesses. A command register zeroes the transmit group, the receive group, or both groups on one edge.

Each wrap from all-ones to zero latches a per-counter rollover flag. Software counts these flags to extend each counter to 64 bits. Per-counter enables select which flags feed a summary bit, and a host mask bit gates that summary onto `irq`.

Top module: `evt_stat_bank`

## Requirements
- R1: Each counter is 32 bits wide and resets to zero. A pulse on its `ev_inc` bit adds one, and the value 0xFFFFFFFF steps to 0.
- R2: The register offsets on `bus_addr` are as follows: 0 access control, 1 data, 2 command, 3 transmit enable, 4 receive enable, 5 transmit status, 6 receive status, 7 host summary, 8 host mask. The access control register holds the counter index in bits [5:0], write mode in bit 8 (1 = write), clear-on-read in bit 9 and auto-advance in bit 10. It reads back as written and resets to 0.
- R3: A read of the data register returns the selected counter, combinationally, in the same cycle. In write mode, a data write loads the selected counter. In read mode, a data write leaves every counter unchanged.
- R4: In read mode with clear-on-read set, a data read returns the counter value and zeroes the counter on that edge. An increment on the same edge is lost, so the counter ends at 0.
- R5: With auto-advance set, every data read or write adds one to the index, modulo 64. With auto-advance clear, the index holds.
- R6: Writing the command register with bit 0 set zeroes counters 0 to 14. Writing it with bit 1 set zeroes counters 15 to 39. Both bits together clear all 40 counters on one edge, and increments on that edge are lost.
- R7: Bit k of the transmit enable register belongs to counter k (k = 0 to 14). Bit k of the receive enable register belongs to counter 15+k (k = 0 to 24). Both registers read back as written.
- R8: A counter wrap sets its status bit whether or not that counter is enabled. Transmit status bit k belongs to counter k and receive status bit k to counter 15+k. Writing a 1 clears a status bit and writing a 0 has no effect. A wrap on the same edge as the clear keeps the bit set.
- R9: Bit 0 of the host summary register is 1 exactly when some status bit is set and also enabled. `irq` equals that summary ANDed with bit 0 of the host mask, and both are 0 after reset.
- R10: A data access at an index from 40 to 63 reads as 0 and writes nothing. The index still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_inc | input | 40 | One increment pulse per counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on the data register only) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Masked rollover interrupt |

## Verification
The bench sweeps all 64 indices through the data port in both directions. A design that mishandled the 40-to-63 hole, or that did not wrap the index from 63 to 0, would return nonzero data or leave the index in the wrong place after the sweep. It steps counters across the all-ones boundary and then checks the status bits, the enable gating, the summary and the mask separately. A design that lets the enable gate the status bit, or that ignores the mask, shows the wrong `irq` level. The bench also hits collisions on a single edge: a status clear against a wrap, a clear-on-read against an increment, and a group clear against increments. A design with the wrong priority would drop a rollover or end with a counter at 1 instead of 0.

// File: rtl/evt_stat_pkg.sv
// Shared definitions for the statistics counter bank: register offsets and
// the bit positions of the access control register fields.
package evt_stat_pkg;
    typedef enum logic [3:0] {
        RA_CTL   = 4'd0,
        RA_DATA  = 4'd1,
        RA_CMD   = 4'd2,
        RA_TXEN  = 4'd3,
        RA_RXEN  = 4'd4,
        RA_TXST  = 4'd5,
        RA_RXST  = 4'd6,
        RA_HSTAT = 4'd7,
        RA_HMASK = 4'd8
    } reg_addr_e;

    localparam int CTL_MODE_BIT = 8;
    localparam int CTL_COR_BIT  = 9;
    localparam int CTL_AINC_BIT = 10;
endpackage

// File: rtl/stat_ctr_bank.sv
// Array of free-running event counters.
// Per counter the priority is: clear > load > increment. A wrap pulse is
// raised only when an increment actually takes the counter from all-ones to
// zero. Assumes at most one load index per cycle.
module stat_ctr_bank #(
    parameter int N  = 40,
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  inc,
    input  logic [N-1:0]  clr,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_idx,
    input  logic [W-1:0]  ld_val,
    output logic [W-1:0]  cnt [N],
    output logic [N-1:0]  wrap
);
    for (genvar i = 0; i < N; i++) begin : g_ctr
        logic hit_ld;
        assign hit_ld = ld_en && (ld_idx == AW'(i));

        // Update one counter: clear, software load or event increment.
        always_ff @(posedge clk) begin
            if (!rst_n)       cnt[i] <= '0;
            else if (clr[i])  cnt[i] <= '0;
            else if (hit_ld)  cnt[i] <= ld_val;
            else if (inc[i])  cnt[i] <= cnt[i] + 1'b1;
        end

        assign wrap[i] = inc[i] && !clr[i] && !hit_ld && (cnt[i] == '1);
    end
endmodule

// File: rtl/stat_acc_port.sv
// Indirect access port: the access control register (index, mode,
// clear-on-read, auto-advance) and the data register path into the counters.
// Indices at or above N select nothing: reads give zero, writes are dropped.
module stat_acc_port #(
    parameter int N  = 40,
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [AW-1:0] ctl_idx,
    input  logic          ctl_mode,
    input  logic          ctl_cor,
    input  logic          ctl_ainc,
    input  logic          dat_rd,
    input  logic          dat_wr,
    input  logic [W-1:0]  cnt [N],
    output logic [AW-1:0] acc_addr,
    output logic          acc_mode,
    output logic          acc_cor,
    output logic          acc_ainc,
    output logic [W-1:0]  dat_rdata,
    output logic [N-1:0]  cor_clr,
    output logic          ld_en
);
    // Hold the control fields; advance the index on each data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_addr <= '0;
            acc_mode <= 1'b0;
            acc_cor  <= 1'b0;
            acc_ainc <= 1'b0;
        end else if (ctl_wr) begin
            acc_addr <= ctl_idx;
            acc_mode <= ctl_mode;
            acc_cor  <= ctl_cor;
            acc_ainc <= ctl_ainc;
        end else if ((dat_rd || dat_wr) && acc_ainc) begin
            acc_addr <= acc_addr + 1'b1;
        end
    end

    // Select the addressed counter; an index with no counter yields zero.
    always_comb begin
        dat_rdata = '0;
        for (int i = 0; i < N; i++)
            if (acc_addr == AW'(i)) dat_rdata = cnt[i];
    end

    // Clear-on-read strobe for the addressed counter.
    for (genvar i = 0; i < N; i++) begin : g_cor
        assign cor_clr[i] = dat_rd && !acc_mode && acc_cor && (acc_addr == AW'(i));
    end

    assign ld_en = dat_wr && acc_mode;
endmodule

// File: rtl/stat_roll_ctrl.sv
// Rollover flags: per-counter enables, write-one-to-clear status bits, the
// enabled summary and the masked interrupt. A wrap wins over a clear on the
// same edge. Assumes NT <= EW and NR <= EW.
module stat_roll_ctrl #(
    parameter int NT = 15,
    parameter int NR = 25,
    parameter int EW = 25
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NT+NR-1:0] wrap,
    input  logic [EW-1:0]   wdata,
    input  logic            txen_wr,
    input  logic            rxen_wr,
    input  logic            txst_w1c,
    input  logic            rxst_w1c,
    input  logic            mask_wr,
    output logic [NT-1:0]   tx_en,
    output logic [NR-1:0]   rx_en,
    output logic [NT-1:0]   tx_st,
    output logic [NR-1:0]   rx_st,
    output logic            hmask,
    output logic            summary,
    output logic            irq
);
    logic [NT-1:0] tx_clr;
    logic [NR-1:0] rx_clr;

    assign tx_clr = txst_w1c ? wdata[NT-1:0] : '0;
    assign rx_clr = rxst_w1c ? wdata[NR-1:0] : '0;

    // Enable and mask registers, loaded by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= '0;
            rx_en <= '0;
            hmask <= 1'b0;
        end else begin
            if (txen_wr) tx_en <= wdata[NT-1:0];
            if (rxen_wr) rx_en <= wdata[NR-1:0];
            if (mask_wr) hmask <= wdata[0];
        end
    end

    // Status bits: set on wrap, cleared by writing ones; the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_st <= '0;
            rx_st <= '0;
        end else begin
            tx_st <= (tx_st & ~tx_clr) | wrap[NT-1:0];
            rx_st <= (rx_st & ~rx_clr) | wrap[NT+NR-1:NT];
        end
    end

    assign summary = (|(tx_st & tx_en)) || (|(rx_st & rx_en));
    assign irq     = summary && hmask;
endmodule

// File: rtl/evt_stat_bank.sv
// Top of the statistics counter bank: register decode, group clear,
// read-data multiplexer and the three sub-blocks.
// Assumes the register bus issues at most one access per cycle.
module evt_stat_bank #(
    parameter int NUM_TX = 15,
    parameter int NUM_RX = 25,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_TX+NUM_RX-1:0] ev_inc,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [3:0]               bus_addr,
    input  logic [CNT_W-1:0]         bus_wdata,
    output logic [CNT_W-1:0]         bus_rdata,
    output logic                     irq
);
    import evt_stat_pkg::*;

    localparam int NUM_CTR = NUM_TX + NUM_RX;
    localparam int EN_W    = (NUM_TX > NUM_RX) ? NUM_TX : NUM_RX;

    logic [CNT_W-1:0]   ctr_val [NUM_CTR];
    logic [NUM_CTR-1:0] ctr_wrap;
    logic [NUM_CTR-1:0] cor_clr;
    logic [NUM_CTR-1:0] grp_clr;
    logic [NUM_CTR-1:0] all_clr;
    logic [ADDR_W-1:0]  acc_addr;
    logic               acc_mode, acc_cor, acc_ainc;
    logic [CNT_W-1:0]   dat_rdata;
    logic               ld_en;
    logic [NUM_TX-1:0]  tx_en, tx_st;
    logic [NUM_RX-1:0]  rx_en, rx_st;
    logic               hmask, summary;
    logic               wr_ctl, wr_cmd, acc_rd, acc_wr;

    assign wr_ctl  = bus_wr && (bus_addr == RA_CTL);
    assign wr_cmd  = bus_wr && (bus_addr == RA_CMD);
    assign acc_rd  = bus_rd && (bus_addr == RA_DATA);
    assign acc_wr  = bus_wr && (bus_addr == RA_DATA);
    assign grp_clr = {{NUM_RX{wr_cmd && bus_wdata[1]}}, {NUM_TX{wr_cmd && bus_wdata[0]}}};
    assign all_clr = grp_clr | cor_clr;

    stat_ctr_bank #(.N(NUM_CTR), .W(CNT_W), .AW(ADDR_W)) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (ev_inc),
        .clr    (all_clr),
        .ld_en  (ld_en),
        .ld_idx (acc_addr),
        .ld_val (bus_wdata),
        .cnt    (ctr_val),
        .wrap   (ctr_wrap)
    );

    stat_acc_port #(.N(NUM_CTR), .W(CNT_W), .AW(ADDR_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (wr_ctl),
        .ctl_idx   (bus_wdata[ADDR_W-1:0]),
        .ctl_mode  (bus_wdata[CTL_MODE_BIT]),
        .ctl_cor   (bus_wdata[CTL_COR_BIT]),
        .ctl_ainc  (bus_wdata[CTL_AINC_BIT]),
        .dat_rd    (acc_rd),
        .dat_wr    (acc_wr),
        .cnt       (ctr_val),
        .acc_addr  (acc_addr),
        .acc_mode  (acc_mode),
        .acc_cor   (acc_cor),
        .acc_ainc  (acc_ainc),
        .dat_rdata (dat_rdata),
        .cor_clr   (cor_clr),
        .ld_en     (ld_en)
    );

    stat_roll_ctrl #(.NT(NUM_TX), .NR(NUM_RX), .EW(EN_W)) u_roll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (ctr_wrap),
        .wdata    (bus_wdata[EN_W-1:0]),
        .txen_wr  (bus_wr && (bus_addr == RA_TXEN)),
        .rxen_wr  (bus_wr && (bus_addr == RA_RXEN)),
        .txst_w1c (bus_wr && (bus_addr == RA_TXST)),
        .rxst_w1c (bus_wr && (bus_addr == RA_RXST)),
        .mask_wr  (bus_wr && (bus_addr == RA_HMASK)),
        .tx_en    (tx_en),
        .rx_en    (rx_en),
        .tx_st    (tx_st),
        .rx_st    (rx_st),
        .hmask    (hmask),
        .summary  (summary),
        .irq      (irq)
    );

    // Read-data multiplexer over the register map.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_CTL: begin
                bus_rdata[ADDR_W-1:0]   = acc_addr;
                bus_rdata[CTL_MODE_BIT] = acc_mode;
                bus_rdata[CTL_COR_BIT]  = acc_cor;
                bus_rdata[CTL_AINC_BIT] = acc_ainc;
            end
            RA_DATA:  bus_rdata = dat_rdata;
            RA_TXEN:  bus_rdata = CNT_W'(tx_en);
            RA_RXEN:  bus_rdata = CNT_W'(rx_en);
            RA_TXST:  bus_rdata = CNT_W'(tx_st);
            RA_RXST:  bus_rdata = CNT_W'(rx_st);
            RA_HSTAT: bus_rdata = CNT_W'(summary);
            RA_HMASK: bus_rdata = CNT_W'(hmask);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_stat_bank_chk.sv
// Assertion checker for evt_stat_bank, attached with bind below.
// Observes the bus, the access index, the wrap pulses, the status bits and
// the counter values.
module evt_stat_bank_chk #(
    parameter int NUM_TX = 15,
    parameter int NUM_RX = 25,
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 6
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [3:0]               bus_addr,
    input logic [CNT_W-1:0]         bus_wdata,
    input logic [CNT_W-1:0]         bus_rdata,
    input logic                     irq,
    input logic [ADDR_W-1:0]        acc_addr,
    input logic                     acc_ainc,
    input logic [NUM_TX+NUM_RX-1:0] ctr_wrap,
    input logic [NUM_TX-1:0]        tx_st,
    input logic [NUM_RX-1:0]        rx_st,
    input logic                     hmask,
    input logic [CNT_W-1:0]         ctr_val [NUM_TX+NUM_RX]
);
    import evt_stat_pkg::*;
    localparam int NUM_CTR = NUM_TX + NUM_RX;

    logic data_acc;
    assign data_acc = (bus_rd || bus_wr) && (bus_addr == RA_DATA);

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && acc_ainc |=> acc_addr == ADDR_W'($past(acc_addr) + 1'b1)); // R5
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc && !acc_ainc |=> $stable(acc_addr)); // R5
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == RA_TXST) |=> (tx_st & $past(tx_st)) == $past(tx_st)); // R8
    AST_WRAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ctr_wrap) |=> ({rx_st, tx_st} & $past(ctr_wrap)) == $past(ctr_wrap)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> hmask); // R9
    AST_GROUP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == RA_CMD && bus_wdata[1:0] == 2'b11
        |=> ctr_val[0] == '0 && ctr_val[NUM_CTR-1] == '0); // R6
    AST_OOR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == RA_DATA && int'(acc_addr) >= NUM_CTR |-> bus_rdata == '0); // R10
endmodule

bind evt_stat_bank evt_stat_bank_chk #(
    .NUM_TX(NUM_TX), .NUM_RX(NUM_RX), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .acc_addr(acc_addr), .acc_ainc(acc_ainc),
    .ctr_wrap(ctr_wrap), .tx_st(tx_st), .rx_st(rx_st), .hmask(hmask),
    .ctr_val(ctr_val)
);

// File: tb/evt_stat_bank_test.sv
// Self-checking bench: index sweeps over the full 64-entry space, wrap and
// interrupt paths, and collisions on a single edge. All expectations come
// from a software model of the counters kept in the bench.
module evt_stat_bank_test;
    localparam int NT = 15;
    localparam int NR = 25;
    localparam int N  = NT + NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  ev_inc = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [3:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [N];
    logic [31:0] rv;

    evt_stat_bank uut (
        .clk(clk), .rst_n(rst_n), .ev_inc(ev_inc), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] ctlv(int idx, bit mode, bit cor, bit ainc);
        return {21'd0, ainc, cor, mode, 2'b00, 6'(idx)};
    endfunction

    function automatic logic [31:0] seed(int i);
        return 32'(i) * 32'h9E37_79B9 + 32'h0000_1001;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic pulse(logic [N-1:0] v);
        @(negedge clk);
        ev_inc = v;
        @(posedge clk); #1;
        ev_inc = '0;
    endtask

    // Read every counter through the auto-advancing port and compare (R1, R3).
    task automatic sweep(string req);
        logic [31:0] d;
        wr(4'd0, ctlv(0, 0, 0, 1));
        for (int i = 0; i < N; i++) begin
            rd(4'd1, d);
            chk(req, d, model[i]);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state (R1, R2, R9)
        #1 chk("R9 irq after reset", {31'd0, irq}, 32'd0);
        rd(4'd0, rv); chk("R2 ctl reset", rv, 32'd0);
        rd(4'd7, rv); chk("R9 summary reset", rv, 32'd0);
        sweep("R1 counters reset");

        // Fill all 64 indices in write mode; the index wraps back to 0 (R3, R5, R10)
        wr(4'd0, ctlv(0, 1, 0, 1));
        rd(4'd0, rv); chk("R2 ctl readback", rv, 32'h0000_0500);
        for (int i = 0; i < 64; i++) begin
            wr(4'd1, seed(i));
            if (i < N) model[i] = seed(i);
        end
        rd(4'd0, rv); chk("R5 index wraps mod 64", rv, 32'h0000_0500);

        // Read all 64 indices: holes read zero (R3, R10)
        wr(4'd0, ctlv(0, 0, 0, 1));
        for (int i = 0; i < 64; i++) begin
            rd(4'd1, rv);
            chk(i < N ? "R3 data read" : "R10 hole reads zero", rv, i < N ? model[i] : 32'd0);
        end
        rd(4'd0, rv); chk("R5 index after read sweep", rv, ctlv(0, 0, 0, 1));

        // Write in read mode is ignored but still advances (R3, R5)
        wr(4'd0, ctlv(3, 0, 0, 1));
        wr(4'd1, 32'hDEAD_BEEF);
        rd(4'd0, rv); chk("R5 index after write", rv, ctlv(4, 0, 0, 1));
        wr(4'd0, ctlv(3, 0, 0, 0));
        rd(4'd1, rv); chk("R3 read-mode write ignored", rv, model[3]);
        rd(4'd1, rv); chk("R5 no advance second read", rv, model[3]);
        rd(4'd0, rv); chk("R5 index holds", rv, ctlv(3, 0, 0, 0));

        // Increment patterns (R1)
        for (int c = 0; c < 24; c++) begin
            logic [N-1:0] p;
            for (int i = 0; i < N; i++) p[i] = ((i * 7 + c * 3) % 5) < 2;
            pulse(p);
            for (int i = 0; i < N; i++) if (p[i]) model[i] = model[i] + 1;
        end
        sweep("R1 increment count");

        // Clear any status left over, then set up wraps (R8, R9, R7)
        wr(4'd5, 32'hFFFF_FFFF);
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd0, ctlv(2, 1, 0, 0));
        wr(4'd1, 32'hFFFF_FFFF);
        wr(4'd0, ctlv(20, 1, 0, 0));
        wr(4'd1, 32'hFFFF_FFFE);
        wr(4'd3, 32'h0000_0004);
        wr(4'd8, 32'h1);
        rd(4'd3, rv); chk("R7 tx enable readback", rv, 32'h4);
        pulse(N'(1) << 2);
        #1 chk("R9 irq on enabled wrap", {31'd0, irq}, 32'd1);
        rd(4'd5, rv); chk("R8 tx status set", rv, 32'h4);
        wr(4'd0, ctlv(2, 0, 0, 0));
        rd(4'd1, rv); chk("R1 wrap to zero", rv, 32'd0);
        model[2] = 32'd0;
        rd(4'd7, rv); chk("R9 summary set", rv, 32'd1);
        wr(4'd8, 32'h0);
        #1 chk("R9 mask blocks irq", {31'd0, irq}, 32'd0);
        rd(4'd7, rv); chk("R9 summary kept while masked", rv, 32'd1);
        wr(4'd5, 32'h0000_0000);
        rd(4'd5, rv); chk("R8 zero write keeps status", rv, 32'h4);
        wr(4'd5, 32'h0000_0004);
        rd(4'd5, rv); chk("R8 w1c clears", rv, 32'h0);
        rd(4'd7, rv); chk("R9 summary falls", rv, 32'd0);

        // Receive wrap without enable (R8, R9, R7)
        wr(4'd8, 32'h1);
        pulse(N'(1) << 20);
        pulse(N'(1) << 20);
        model[20] = 32'd0;
        rd(4'd6, rv); chk("R8 rx status set while disabled", rv, 32'h20);
        #1 chk("R9 no irq without enable", {31'd0, irq}, 32'd0);
        wr(4'd4, 32'h0000_0020);
        rd(4'd4, rv); chk("R7 rx enable readback", rv, 32'h20);
        #1 chk("R7 rx enable bit 5 drives irq", {31'd0, irq}, 32'd1);
        wr(4'd6, 32'h0000_0020);
        #1 chk("R9 irq falls after rx clear", {31'd0, irq}, 32'd0);

        // Wrap on the same edge as the status clear (R8)
        wr(4'd0, ctlv(2, 1, 0, 0));
        wr(4'd1, 32'hFFFF_FFFF);
        pulse(N'(1) << 2);
        wr(4'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 32'h4; ev_inc = N'(1) << 2;
        @(posedge clk); #1;
        bus_wr = 1'b0; ev_inc = '0;
        model[2] = 32'd0;
        rd(4'd5, rv); chk("R8 wrap beats clear", rv, 32'h4);
        wr(4'd5, 32'h4);

        // Clear-on-read with an increment on the same edge (R4)
        wr(4'd0, ctlv(7, 0, 1, 0));
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 4'd1; ev_inc = N'(1) << 7;
        #1 rv = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0; ev_inc = '0;
        chk("R4 cor returns old value", rv, model[7]);
        model[7] = 32'd0;
        wr(4'd0, ctlv(30, 0, 1, 1));
        rd(4'd1, rv); chk("R4 cor value", rv, model[30]);
        model[30] = 32'd0;
        sweep("R4 counters after cor");

        // Group clears (R6)
        wr(4'd2, 32'h1);
        for (int i = 0; i < NT; i++) model[i] = 32'd0;
        sweep("R6 tx-only clear");
        wr(4'd0, ctlv(0, 1, 0, 1));
        for (int i = 0; i < N; i++) begin
            wr(4'd1, seed(i + 100));
            model[i] = seed(i + 100);
        end
        wr(4'd2, 32'h2);
        for (int i = NT; i < N; i++) model[i] = 32'd0;
        sweep("R6 rx-only clear");
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h3; ev_inc = '1;
        @(posedge clk); #1;
        bus_wr = 1'b0; ev_inc = '0;
        for (int i = 0; i < N; i++) model[i] = 32'd0;
        sweep("R6 full clear beats increment");

        // Writes into the hole leave the bank untouched (R10)
        pulse('1);
        for (int i = 0; i < N; i++) model[i] = 32'd1;
        wr(4'd0, ctlv(45, 1, 0, 1));
        wr(4'd1, 32'h1234_5678);
        rd(4'd0, rv); chk("R10 hole write advances", rv, ctlv(46, 1, 0, 1));
        wr(4'd0, ctlv(45, 0, 0, 0));
        rd(4'd1, rv); chk("R10 hole still zero", rv, 32'd0);
        sweep("R10 bank unchanged");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule